// File: doc/BRIEF.md
# Stereo De-emphasis Filter

This block sits in the playback path ahead of the interpolator and undoes the treble lift that pre-emphasised recordings carry. Every accepted sample pair runs through a first-order shelving IIR with a pole at 50 µs and a zero at 15 µs. The filter is discretised by bilinear transform for three sample rates, and the coefficients are fixed signed constants with 16 fractional bits. The filter can also be switched off, and then samples pass through unchanged.

Samples are 20-bit two's complement. A one-cycle strobe marks each left/right pair. The result pair comes out one clock later with its own strobe and holds until the next pair. The left and right channels keep separate history. History is zeroed whenever the filter is bypassed or the rate code changes, so old samples are never mixed with a different coefficient set.

Top module: `deemph_stereo`

## Requirements
- R1: While reset is asserted and after it is released, `out_vld` is 0 and both output samples are 0 until the first accepted sample.
- R2: `out_vld` is high in the cycle after each cycle in which `in_vld` is high, and low otherwise. The output samples change only in that cycle.
- R3: With `mode_sel` = 01 (off), an accepted pair appears unchanged on the outputs one cycle later.
- R4: When `in_vld` is low, both output samples keep their previous values.
- R5: When filtering, each channel computes y = clamp(floor((b0·x + b1·x1 − a1·y1 + 2^15) / 2^16)). Here x1 is the previous accepted input of that channel and y1 is its previous filtered output, and both are 0 after reset.
- R6: Coefficients (b0, b1, a1) as integers scaled by 2^16: `mode_sel` = 00 (44.1 kHz) uses 28141, −3913, −41308; 10 (48 kHz) uses 27570, −4972, −42937; 11 (32 kHz) uses 30583, 624, −34328.
- R7: The left and right channels keep independent history. The data on one channel never affects the other channel's output.
- R8: Filtered results are clamped to the range 80000h..7FFFFh and do not wrap.
- R9: An accepted sample in bypass mode zeroes both channels' history, so the first filtered sample afterwards uses x1 = y1 = 0.
- R10: When `mode_sel` differs from its value in the previous cycle, history is zeroed, whether or not a sample arrives in that cycle. A sample that arrives in that cycle is filtered with zero history.
- R11: A constant input in mode 00 settles to an output within one LSB of the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Rate code: 00 = 44.1 kHz, 01 = off, 10 = 48 kHz, 11 = 32 kHz |
| in_vld | input | 1 | Input pair strobe |
| in_left | input | 20 | Left input sample, two's complement |
| in_right | input | 20 | Right input sample, two's complement |
| out_vld | output | 1 | Output pair strobe |
| out_left | output | 20 | Left filtered sample |
| out_right | output | 20 | Right filtered sample |

## Verification
The hardest cases to reach are a rate-code change in exactly the cycle of a sample, and a change in an idle cycle that must still zero history before the next sample. The stimulus reaches both by switching `mode_sel` both with and without `in_vld` in the same cycle, and by moving between bypass and each rate. Full-scale steps of both polarities drive the accumulator to its extremes, so that the clamp and the rounding bias are exercised. Runs with one channel held at zero and the other driven randomly show that the channels stay separate.

// File: rtl/deemph_pkg.sv
package deemph_pkg;

  localparam int SMP_W  = 20;
  localparam int COEF_W = 18;
  localparam int FRAC_W = 16;

  typedef enum logic [1:0] {
    DM_R441 = 2'b00,
    DM_OFF  = 2'b01,
    DM_R48  = 2'b10,
    DM_R32  = 2'b11
  } de_mode_e;

  // bilinear-transformed shelf coefficients, scaled by 2^FRAC_W
  localparam logic signed [COEF_W-1:0] B0_441 = 18'sd28141;
  localparam logic signed [COEF_W-1:0] B1_441 = -18'sd3913;
  localparam logic signed [COEF_W-1:0] A1_441 = -18'sd41308;
  localparam logic signed [COEF_W-1:0] B0_48  = 18'sd27570;
  localparam logic signed [COEF_W-1:0] B1_48  = -18'sd4972;
  localparam logic signed [COEF_W-1:0] A1_48  = -18'sd42937;
  localparam logic signed [COEF_W-1:0] B0_32  = 18'sd30583;
  localparam logic signed [COEF_W-1:0] B1_32  = 18'sd624;
  localparam logic signed [COEF_W-1:0] A1_32  = -18'sd34328;

endpackage

// File: rtl/deemph_coef_sel.sv
module deemph_coef_sel
  import deemph_pkg::*;
#(
  parameter int COEF_W = deemph_pkg::COEF_W
) (
  input  logic [1:0]               mode_sel,
  output logic signed [COEF_W-1:0] b0,
  output logic signed [COEF_W-1:0] b1,
  output logic signed [COEF_W-1:0] a1,
  output logic                     bypass
);

  always_comb begin
    bypass = 1'b0;
    b0     = '0;
    b1     = '0;
    a1     = '0;
    unique case (de_mode_e'(mode_sel))
      DM_R441: begin b0 = COEF_W'(B0_441); b1 = COEF_W'(B1_441); a1 = COEF_W'(A1_441); end
      DM_R48:  begin b0 = COEF_W'(B0_48);  b1 = COEF_W'(B1_48);  a1 = COEF_W'(A1_48);  end
      DM_R32:  begin b0 = COEF_W'(B0_32);  b1 = COEF_W'(B1_32);  a1 = COEF_W'(A1_32);  end
      default: bypass = 1'b1;
    endcase
  end

endmodule

// File: rtl/deemph_chan.sv
module deemph_chan #(
  parameter int DATA_W = 20,
  parameter int COEF_W = 18,
  parameter int FRAC_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     smp_en,
  input  logic                     hist_clr,
  input  logic                     bypass,
  input  logic signed [COEF_W-1:0] b0,
  input  logic signed [COEF_W-1:0] b1,
  input  logic signed [COEF_W-1:0] a1,
  input  logic signed [DATA_W-1:0] x_in,
  output logic signed [DATA_W-1:0] y_out
);

  localparam int ACC_W = DATA_W + COEF_W + 2;
  localparam logic signed [ACC_W-1:0] RND  = ACC_W'(1) <<< (FRAC_W - 1);
  localparam logic signed [ACC_W-1:0] MAXV = (ACC_W'(1) <<< (DATA_W - 1)) - ACC_W'(1);
  localparam logic signed [ACC_W-1:0] MINV = -(ACC_W'(1) <<< (DATA_W - 1));

  logic signed [DATA_W-1:0] x1_q, x1_d, y1_q, y1_d, y_q, y_d;
  logic signed [DATA_W-1:0] x1_use, y1_use, y_sat;
  logic signed [ACC_W-1:0]  p_cur, p_old, p_fb, acc, shf;

  // arithmetic path
  always_comb begin
    x1_use = hist_clr ? '0 : x1_q;
    y1_use = hist_clr ? '0 : y1_q;
    p_cur  = ACC_W'(x_in)   * ACC_W'(b0);
    p_old  = ACC_W'(x1_use) * ACC_W'(b1);
    p_fb   = ACC_W'(y1_use) * ACC_W'(a1);
    acc    = p_cur + p_old - p_fb + RND;
    shf    = acc >>> FRAC_W;
    if (shf > MAXV)      y_sat = MAXV[DATA_W-1:0];
    else if (shf < MINV) y_sat = MINV[DATA_W-1:0];
    else                 y_sat = shf[DATA_W-1:0];
  end

  // next state
  always_comb begin
    y_d  = y_q;
    x1_d = x1_use;
    y1_d = y1_use;
    if (smp_en) begin
      if (bypass) begin
        y_d  = x_in;
        x1_d = '0;
        y1_d = '0;
      end else begin
        y_d  = y_sat;
        x1_d = x_in;
        y1_d = y_sat;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x1_q <= '0;
      y1_q <= '0;
      y_q  <= '0;
    end else begin
      x1_q <= x1_d;
      y1_q <= y1_d;
      y_q  <= y_d;
    end
  end

  assign y_out = y_q;

endmodule

// File: rtl/deemph_stereo.sv
module deemph_stereo
  import deemph_pkg::*;
#(
  parameter int DATA_W = deemph_pkg::SMP_W,
  parameter int COEF_W = deemph_pkg::COEF_W,
  parameter int FRAC_W = deemph_pkg::FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_sel,
  input  logic              in_vld,
  input  logic [DATA_W-1:0] in_left,
  input  logic [DATA_W-1:0] in_right,
  output logic              out_vld,
  output logic [DATA_W-1:0] out_left,
  output logic [DATA_W-1:0] out_right
);

  localparam int NCH = 2;

  logic signed [COEF_W-1:0] c_b0, c_b1, c_a1;
  logic                     bypass;
  logic [1:0]               mode_q;
  logic                     hist_clr;
  logic                     vld_q, vld_d;
  logic signed [DATA_W-1:0] ch_in  [NCH];
  logic signed [DATA_W-1:0] ch_out [NCH];

  deemph_coef_sel #(.COEF_W(COEF_W)) coef_i (
    .mode_sel (mode_sel),
    .b0       (c_b0),
    .b1       (c_b1),
    .a1       (c_a1),
    .bypass   (bypass)
  );

  assign hist_clr = bypass | (mode_sel != mode_q);
  assign vld_d    = in_vld;
  assign ch_in[0] = in_left;
  assign ch_in[1] = in_right;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 2'b01;
      vld_q  <= 1'b0;
    end else begin
      mode_q <= mode_sel;
      vld_q  <= vld_d;
    end
  end

  for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
    deemph_chan #(
      .DATA_W (DATA_W),
      .COEF_W (COEF_W),
      .FRAC_W (FRAC_W)
    ) chan_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .smp_en   (in_vld),
      .hist_clr (hist_clr),
      .bypass   (bypass),
      .b0       (c_b0),
      .b1       (c_b1),
      .a1       (c_a1),
      .x_in     (ch_in[gi]),
      .y_out    (ch_out[gi])
    );
  end

  assign out_vld   = vld_q;
  assign out_left  = ch_out[0];
  assign out_right = ch_out[1];

endmodule

// File: rtl/deemph_stereo_chk.sv
module deemph_stereo_chk #(
  parameter int DATA_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode_sel,
  input logic              in_vld,
  input logic [DATA_W-1:0] in_left,
  input logic [DATA_W-1:0] in_right,
  input logic              out_vld,
  input logic [DATA_W-1:0] out_left,
  input logic [DATA_W-1:0] out_right
);

  AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld); // R2

  AST_VLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !out_vld); // R2

  AST_BYPASS_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && mode_sel == 2'b01) |=>
      (out_left == $past(in_left) && out_right == $past(in_right))); // R3

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> ($stable(out_left) && $stable(out_right))); // R4

  AST_CHG_ZERO_HIST: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && mode_sel != $past(mode_sel) && in_left == '0) |=> out_left == '0); // R10

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (!out_vld); // R1
    end
  end

endmodule

bind deemph_stereo deemph_stereo_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/deemph_stereo_tb_top.sv
module deemph_stereo_tb_top;

  localparam int W = 20;
  localparam longint MAXV = 524287;
  localparam longint MINV = -524288;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [1:0]   mode_sel;
  logic         in_vld;
  logic [W-1:0] in_left, in_right;
  logic         out_vld;
  logic [W-1:0] out_left, out_right;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string tag = "R1";

  // reference model state
  longint mx1 [2];
  longint my1 [2];
  logic [1:0] mprev;
  logic   exp_vld;
  longint exp_y [2];

  always #5 clk = ~clk;

  deemph_stereo dut_i (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .in_vld(in_vld),
    .in_left(in_left), .in_right(in_right), .out_vld(out_vld),
    .out_left(out_left), .out_right(out_right)
  );

  function automatic longint sx(input logic [W-1:0] v);
    return longint'($signed(v));
  endfunction

  function automatic void coefs(input logic [1:0] m, output longint b0,
                                output longint b1, output longint a1);
    case (m)
      2'b00:   begin b0 = 28141; b1 = -3913; a1 = -41308; end // R6
      2'b10:   begin b0 = 27570; b1 = -4972; a1 = -42937; end // R6
      default: begin b0 = 30583; b1 = 624;   a1 = -34328; end // R6
    endcase
  endfunction

  function automatic void model(input logic [1:0] m, input logic v,
                                input longint xl, input longint xr);
    longint b0, b1, a1, acc, y, x;
    bit hz;
    hz = (m != mprev) || (m == 2'b01);
    if (hz) begin
      for (int c = 0; c < 2; c++) begin mx1[c] = 0; my1[c] = 0; end
    end
    if (v) begin
      for (int c = 0; c < 2; c++) begin
        x = (c == 0) ? xl : xr;
        if (m == 2'b01) begin
          exp_y[c] = x;
        end else begin
          coefs(m, b0, b1, a1);
          acc = b0 * x + b1 * mx1[c] - a1 * my1[c] + 32768;
          y = acc >>> 16;
          if (y > MAXV) y = MAXV;
          if (y < MINV) y = MINV;
          exp_y[c] = y;
          mx1[c] = x;
          my1[c] = y;
        end
      end
    end
    exp_vld = v;
    mprev = m;
  endfunction

  task automatic check(input string t, input string what,
                       input longint act, input longint expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", t, what, act, expv);
    end
  endtask

  task automatic compare();
    check(tag, "out_vld", longint'(out_vld), longint'(exp_vld));
    check(tag, "out_left", sx(out_left), exp_y[0]);
    check(tag, "out_right", sx(out_right), exp_y[1]);
  endtask

  task automatic step(input logic [1:0] m, input logic v,
                      input longint l, input longint r);
    @(negedge clk);
    compare();
    mode_sel = m;
    in_vld   = v;
    in_left  = W'(l);
    in_right = W'(r);
    model(m, v, l, r);
  endtask

  function automatic longint rnd();
    return longint'($signed(W'($urandom)));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mode_sel = 2'b01; in_vld = 1'b0;
    in_left = '0; in_right = '0;
    mprev = 2'b01; exp_vld = 1'b0;
    for (int c = 0; c < 2; c++) begin mx1[c] = 0; my1[c] = 0; exp_y[c] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    tag = "R1";
    compare();
    rst_n = 1'b1;
    step(2'b01, 1'b0, 0, 0);
    step(2'b01, 1'b0, 0, 0);

    // bypass traffic, with gaps
    tag = "R3";
    for (int i = 0; i < 40; i++) step(2'b01, (i % 3) != 2, rnd(), rnd());
    tag = "R4";
    for (int i = 0; i < 5; i++) step(2'b01, 1'b0, rnd(), rnd());

    // each rate, random data, sample then gap (R2, R5, R6, R9)
    tag = "R9";
    step(2'b00, 1'b1, 100000, -200000);
    tag = "R5";
    for (int i = 0; i < 60; i++) step(2'b00, (i % 2) == 0, rnd(), rnd());
    tag = "R2";
    for (int i = 0; i < 20; i++) step(2'b00, (i % 4) == 0, rnd(), rnd());
    tag = "R6";
    for (int i = 0; i < 60; i++) step(2'b10, (i % 3) == 0, rnd(), rnd());
    for (int i = 0; i < 60; i++) step(2'b11, 1'b1, rnd(), rnd());

    // mode change in an idle cycle, then samples
    tag = "R10";
    step(2'b00, 1'b1, 300000, 300000);
    step(2'b10, 1'b0, 0, 0);
    step(2'b10, 1'b0, 0, 0);
    step(2'b10, 1'b1, 0, 0);
    step(2'b10, 1'b1, 250000, -250000);
    // mode change on the sample cycle
    step(2'b11, 1'b1, 0, 0);
    step(2'b00, 1'b1, -400000, 400000);
    for (int i = 0; i < 10; i++) step(2'b00, 1'b1, rnd(), rnd());

    // channel separation: left held at zero
    tag = "R7";
    step(2'b01, 1'b1, 0, 0);
    for (int i = 0; i < 40; i++) step(2'b10, 1'b1, 0, rnd());
    for (int i = 0; i < 40; i++) step(2'b11, 1'b1, rnd(), 0);

    // full-scale steps, both polarities
    tag = "R8";
    for (int k = 0; k < 3; k++) begin
      logic [1:0] mm;
      mm = (k == 0) ? 2'b00 : (k == 1) ? 2'b10 : 2'b11;
      for (int i = 0; i < 30; i++) step(mm, 1'b1, MAXV, MINV);
      for (int i = 0; i < 30; i++) step(mm, 1'b1, MINV, MAXV);
      for (int i = 0; i < 20; i++) step(mm, 1'b1, (i % 2) ? MAXV : MINV, (i % 2) ? MINV : MAXV);
    end

    // DC settling
    tag = "R11";
    step(2'b01, 1'b1, 0, 0);
    for (int i = 0; i < 80; i++) step(2'b00, 1'b1, 300000, -123457);
    step(2'b00, 1'b0, 0, 0);
    @(negedge clk);
    compare();
    checks++;
    if (sx(out_left) < 299999 || sx(out_left) > 300001) begin
      errors++;
      $display("FAIL R11 dc left: actual %0d expected 300000+-1", sx(out_left));
    end
    checks++;
    if (sx(out_right) < -123458 || sx(out_right) > -123456) begin
      errors++;
      $display("FAIL R11 dc right: actual %0d expected -123457+-1", sx(out_right));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule